// File: doc/BRIEF.md
# Current-Mode PWM Gate Sequencer

This block is the digital control core of a single-ended, current-mode switching regulator. A free-running oscillator supplies one-clock tick pulses. The block pairs these ticks into switching cycles. The first tick of a pair opens the drive half of the cycle and the second closes it. Because of this, the gate output can never be on for more than half of a switching cycle.

The gate output goes high at the start of each cycle. The pulse ends at whichever comes first:
- a trip from the loop (PWM) comparator;
- a trip from the peak-current comparator;
- the end of the drive half.

Two conditions veto switching: a supply-valid flag, and a pair of active-low control pins. The first control pin stops the output directly. When both control pins are low together, a hold latch is set that keeps the output off until the second pin returns high. The analog parts of a regulator (comparators, reference, error amplifier, oscillator RC and driver stage) are not part of this block. They appear here only as digital inputs.

All inputs except the two control pins are taken as synchronous to `clk`. The two control pins pass through a synchronizer with `SYNC_STAGES` flops (default 2). The block carries no data stream, so there is no valid/ready interface. Every pin is a plain level or pulse.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: Ticks alternate between "cycle start" and "cycle end", beginning with a start after reset. With no trip and no veto, `drv_out` goes high on the clock edge that samples a start tick and low on the edge that samples the following end tick. It is never high outside the drive half.
- R2: While the synchronized `halt_n` is low, `drv_out` is low. With `rearm_n` high, `halt_n` is a plain enable: once it returns high, switching resumes at the next cycle start.
- R3: If the synchronized `halt_n` and `rearm_n` are low in the same clock, the hold latch sets. While it is set, `drv_out` stays low whatever `halt_n` does.
- R4: The hold latch clears only when the synchronized `rearm_n` is high. Pulses then resume from the next cycle start.
- R5: `rearm_n` low while `halt_n` stays high has no effect on switching.
- R6: While `supply_ok` is low, `drv_out` is low from the next clock edge, and no pulse can start.
- R7: `ilim_trip` high during a pulse makes `drv_out` low at the next edge, whatever the state of `loop_trip`.
- R8: `loop_trip` high during a pulse makes `drv_out` low at the next edge. A trip already high at the start tick suppresses that cycle's pulse.
- R9: Once a pulse has ended, `drv_out` stays low until the next cycle start, even if every trip input returns low.
- R10: Asserting `rst_n` low sets `drv_out` low at once and clears the hold latch. It also returns the tick pairing so that the next tick is a cycle start.
- R11: A veto that arrives mid-pulse cuts the pulse within one clock of its (synchronized) level. The tick pairing keeps running, so later cycles start on schedule. `halt_n` therefore takes effect SYNC_STAGES+1 edges after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| osc_tick | input | 1 | One-clock oscillator tick pulse |
| loop_trip | input | 1 | Loop (PWM) comparator trip, active high |
| ilim_trip | input | 1 | Peak-current comparator trip, active high |
| supply_ok | input | 1 | Supply above lockout threshold, active high |
| halt_n | input | 1 | Active-low stop pin, asynchronous |
| rearm_n | input | 1 | Active-low latch-mode / release pin, asynchronous |
| drv_out | output | 1 | Gate drive request |

## Verification
The in-line assertions check the following on every cycle:
- the output never rises except on a cycle-start tick, and never stays high outside the drive half;
- any trip, supply loss or synchronized stop drops the output at the next edge;
- the hold latch holds while the release pin stays low, and clears once it goes high;
- the tick pairing changes only on ticks.

Only the bench scenarios can show that pulse widths follow the arithmetic `min(trip offset, half cycle)`, and that a one-clock trip glitch does not re-trigger a pulse. They also show that the pin sequences around the latch give the expected resume points. Finally, they show that cycle timing survives a mid-pulse veto and is re-aligned by reset.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  // Half of a switching cycle currently in progress
  typedef enum logic {
    PH_REST  = 1'b0,   // between an end tick and the next start tick
    PH_DRIVE = 1'b1    // between a start tick and its end tick
  } half_e;

  localparam int unsigned CTRL_PINS = 2;   // halt_n, rearm_n
  localparam int unsigned PIN_HALT  = 0;
  localparam int unsigned PIN_REARM = 1;
endpackage

// File: rtl/pwm_pin_sync.sv
module pwm_pin_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_s
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stg [STAGES];

  // Pins idle high, so reset the chain high to avoid a spurious latch set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign pin_s = stg[LAST];
endmodule

// File: rtl/pwm_hold_latch.sv
module pwm_hold_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_s,
  input  logic rearm_s,
  output logic run_ok
);
  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  held_q <= 1'b0;
    else if (rearm_s)            held_q <= 1'b0;
    else if (!halt_s)            held_q <= 1'b1;
  end

  assign run_ok = halt_s && !held_q;

  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rearm_s) |=> !run_ok); // R3
  AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_s && halt_s) |=> (run_ok || !halt_s)); // R4
endmodule

// File: rtl/pwm_cycle_former.sv
module pwm_cycle_former
  import pwm_gate_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  osc_tick,
  output half_e half_q,
  output logic  cyc_start,
  output logic  cyc_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        half_q <= PH_REST;
    else if (osc_tick) half_q <= (half_q == PH_REST) ? PH_DRIVE : PH_REST;
  end

  assign cyc_start = osc_tick && (half_q == PH_REST);
  assign cyc_end   = osc_tick && (half_q == PH_DRIVE);

  AST_PHASE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(half_q)); // R11
endmodule

// File: rtl/pwm_pulse_ctrl.sv
module pwm_pulse_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_end,
  input  logic run_ok,
  input  logic supply_ok,
  input  logic loop_trip,
  input  logic ilim_trip,
  output logic drv_q
);
  logic enabled;
  logic tripped;
  logic drv_d;

  assign enabled = run_ok && supply_ok;
  assign tripped = loop_trip || ilim_trip;

  always_comb begin
    drv_d = drv_q;
    if (cyc_start)               drv_d = enabled && !tripped;
    else if (cyc_end)            drv_d = 1'b0;
    else if (tripped || !enabled) drv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_d;
  end

  AST_UNSUPPLIED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !drv_q); // R6
  AST_STOP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> !drv_q); // R2
  AST_ILIM_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ilim_trip |=> !drv_q); // R7
  AST_LOOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    loop_trip |=> !drv_q); // R8
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (!drv_q && !cyc_start) |=> !drv_q); // R9
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl
  import pwm_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic loop_trip,
  input  logic ilim_trip,
  input  logic supply_ok,
  input  logic halt_n,
  input  logic rearm_n,
  output logic drv_out
);
  logic [CTRL_PINS-1:0] pins_raw;
  logic [CTRL_PINS-1:0] pins_s;
  half_e                half_q;
  logic                 cyc_start;
  logic                 cyc_end;
  logic                 run_ok;

  assign pins_raw[PIN_HALT]  = halt_n;
  assign pins_raw[PIN_REARM] = rearm_n;

  pwm_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(CTRL_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pins_raw),
    .pin_s (pins_s)
  );

  pwm_hold_latch u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .halt_s  (pins_s[PIN_HALT]),
    .rearm_s (pins_s[PIN_REARM]),
    .run_ok  (run_ok)
  );

  pwm_cycle_former u_cycle (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .half_q    (half_q),
    .cyc_start (cyc_start),
    .cyc_end   (cyc_end)
  );

  pwm_pulse_ctrl u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cyc_end   (cyc_end),
    .run_ok    (run_ok),
    .supply_ok (supply_ok),
    .loop_trip (loop_trip),
    .ilim_trip (ilim_trip),
    .drv_q     (drv_out)
  );

  AST_HALF_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    drv_out |-> (half_q == PH_DRIVE)); // R1
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !drv_out); // R10
endmodule

// File: tb/pwm_gate_ctrl_tb.sv
module pwm_gate_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic loop_trip = 1'b0;
  logic ilim_trip = 1'b0;
  logic supply_ok = 1'b1;
  logic halt_n = 1'b1;
  logic rearm_n = 1'b1;
  logic drv_out;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  pwm_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .loop_trip(loop_trip),
    .ilim_trip(ilim_trip), .supply_ok(supply_ok), .halt_n(halt_n),
    .rearm_n(rearm_n), .drv_out(drv_out)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_of(input int w);
    return 8'((1 << w) - 1);
  endfunction

  // One switching cycle of 8 clocks: start tick at c=0, end tick at c=4.
  // mode 0 none, 1 loop_trip pulse at c=k, 2 ilim_trip pulse at c=k,
  // 3 supply_ok low from c=k, 4 halt_n low from c=k.
  task automatic run(input int mode, input int k, input int exp_w, input string tag);
    logic [7:0] got;
    got = '0;
    for (int c = 0; c < 8; c++) begin
      osc_tick  = (c == 0 || c == 4);
      loop_trip = (mode == 1 && c == k);
      ilim_trip = (mode == 2 && c == k);
      if (mode == 3 && c == k) supply_ok = 1'b0;
      if (mode == 4 && c == k) halt_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      got[c] = drv_out;
    end
    osc_tick = 1'b0; loop_trip = 1'b0; ilim_trip = 1'b0;
    if (mode == 3) supply_ok = 1'b1;
    if (mode == 4) halt_n = 1'b1;
    idle(4);
    check(got, mask_of(exp_w), tag);
  endtask

  function automatic int min4(input int v);
    return (v < 4) ? v : 4;
  endfunction

  initial begin
    #(20 * 100000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    check({7'd0, drv_out}, 8'd0, "R10 reset state");
    rst_n = 1'b1;
    idle(3);

    // R1: free-running cycles, exactly half duty, aligned to tick pairs
    run(0, 0, 4, "R1 plain cycle");
    run(0, 0, 4, "R1 second cycle");

    // R8 / R9: loop trip one-clock pulse at every offset
    for (int k = 0; k < 7; k++) run(1, k, min4(k), $sformatf("R8 R9 loop trip k=%0d", k));
    // R7: current-limit trip
    for (int k = 0; k < 7; k++) run(2, k, min4(k), $sformatf("R7 ilim trip k=%0d", k));

    // R6 / R11: supply drop mid-pulse, then next cycle on schedule
    for (int k = 0; k < 4; k++) begin
      run(3, k, min4(k), $sformatf("R6 supply drop k=%0d", k));
      run(0, 0, 4, "R11 timing kept after supply drop");
    end
    supply_ok = 1'b0; idle(2);
    run(0, 0, 0, "R6 no start while unsupplied");
    supply_ok = 1'b1; idle(2);

    // R11 / R2: stop pin mid-pulse acts after synchronizer + 1
    for (int k = 0; k < 3; k++) begin
      run(4, k, min4(k + 2), $sformatf("R11 halt drop k=%0d", k));
      run(0, 0, 4, "R11 timing kept after halt");
    end

    // R2: transparent stop
    halt_n = 1'b0; idle(4);
    run(0, 0, 0, "R2 halted");
    halt_n = 1'b1; idle(4);
    run(0, 0, 4, "R2 released resumes");

    // R5: release pin alone
    rearm_n = 1'b0; idle(4);
    run(0, 0, 4, "R5 rearm low alone");
    rearm_n = 1'b1; idle(4);

    // R3 / R4: latching mode
    halt_n = 1'b0; rearm_n = 1'b0; idle(4);
    halt_n = 1'b1; idle(4);
    run(0, 0, 0, "R3 latched after halt release");
    halt_n = 1'b0; idle(3); halt_n = 1'b1; idle(3);
    run(0, 0, 0, "R3 latched ignores halt toggle");
    rearm_n = 1'b1; idle(4);
    run(0, 0, 4, "R4 release clears latch");

    // R10: async reset mid-pulse
    osc_tick = 1'b1; @(posedge clk); @(negedge clk); osc_tick = 1'b0;
    check({7'd0, drv_out}, 8'd1, "R10 pulse before reset");
    #3 rst_n = 1'b0;
    #1 check({7'd0, drv_out}, 8'd0, "R10 immediate low");
    @(negedge clk); rst_n = 1'b1; idle(2);
    run(0, 0, 4, "R10 tick pairing realigned");

    // R10: reset clears the hold latch
    halt_n = 1'b0; rearm_n = 1'b0; idle(4);
    halt_n = 1'b1; idle(4);
    run(0, 0, 0, "R3 latched before reset");
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(4);
    run(0, 0, 4, "R10 reset cleared latch");
    rearm_n = 1'b1; idle(4);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule